// File: doc/BRIEF.md
# Triple-DES Round Counter and Key-Select Sequencer

This block paces a 48-round Triple DES engine: three DES passes of sixteen rounds each. It advances one round on every enabled clock. For each cycle it reports which pass and which round inside that pass the datapath should compute. It raises a one-cycle strobe when a pass starts and its sub-key must be loaded, and it flags the cycle in which the last round runs, so that the result can be captured.

There is a single shared key port, so the three sub-keys come from outside in sequence. A 2-bit key-select output names the sub-key the engine will want next. The sub-key order depends on direction: first, second, third when encrypting, and the reverse when decrypting. Key-select moves one full cycle before that sub-key is consumed. This leaves an external RAM or ROM addressed by the select one cycle to return the key.

Pausing freezes all progress. Clearing abandons the current block and returns to the first round, ready to start a new block on the next cycle. The cipher datapath is outside this block.

Top module: `tdes_key_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block enters round 0 of pass 0 with no valid strobe and no load strobe. Key-select takes the starting code for the level of `enc_i`: 00 when encrypting, 10 when decrypting.
- R2: Each clock with `adv_en_i` high and `clr_i` low moves an internal count forward by one. The count wraps from 47 to 0. `round_o` equals count mod 16 and `pass_o` equals count / 16.
- R3: In encryption, key-select encodes 00 for the first sub-key, 01 for the second and 10 for the third. It reads 00 for counts 0..14, 01 for 15..30, 10 for 31..46, and 00 again at 47.
- R4: In decryption, key-select reads 10 for counts 0..14, 01 for 15..30, 00 for 31..46, and 10 again at 47.
- R5: `valid_o` is high exactly in an advancing cycle at count 47, which is the 48th enabled cycle of a block. It is never high in two consecutive cycles.
- R6: `key_load_o` is high exactly in advancing cycles at counts 0, 16 and 32, with `round_o` equal to 0.
- R7: With `adv_en_i` low and `clr_i` low, the count and key-select hold, and both strobes stay low, for as long as the pause lasts. The one exception is count 0, covered by R10.
- R8: `clr_i` high at a rising edge returns the count to 0 and sets key-select to the starting code of the current `enc_i`. It takes priority over `adv_en_i`, and both strobes are low in that cycle.
- R9: Key-select already shows the next pass's code during the final round of the current pass, one cycle before the `key_load_o` for that pass. It then stays unchanged across that load.
- R10: While paused at count 0, key-select follows the starting code of `enc_i` one cycle later. A direction change between blocks is therefore taken up before the next block starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_en_i | input | 1 | Advance one round per cycle when high; pause when low |
| clr_i | input | 1 | Abandon the current block and return to round 0 |
| enc_i | input | 1 | 1 encrypt, 0 decrypt; hold steady for a whole block |
| round_o | output | 4 | Round inside the current pass, 0..15 |
| pass_o | output | 2 | DES pass index, 0..2 |
| key_load_o | output | 1 | Sub-key for the current pass is consumed this cycle |
| key_sel_o | output | 2 | Sub-key to present next: 00 first, 01 second, 10 third |
| valid_o | output | 1 | Last round of the block runs this cycle |

## Verification
The round, pass, load and valid outputs decode the current count together with this cycle's inputs. They are due in the same cycle as the stimulus. The count and key-select are registers, so any change they make appears one rising edge after the cycle that caused it. The bench sets the inputs just after a falling edge and samples 1 ns later, well before the next rising edge. It keeps its own count and key-select model and moves that model forward by exactly one edge per cycle. This lets it check, at every sample, the one-cycle lead of key-select over the load strobe, the 48th-cycle valid, the pause hold and the clear result.

// File: rtl/tdes_seq_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the Triple-DES round sequencer.
// Assumes at most four passes so that a 2-bit key code is enough.
package tdes_seq_pkg;

    localparam int KSEL_W = 2;

    typedef logic [KSEL_W-1:0] ksel_t;

    // One operation per cycle, in priority order: clear, advance, hold
    typedef enum logic [1:0] {
        SEQ_HOLD    = 2'd0,
        SEQ_ADVANCE = 2'd1,
        SEQ_CLEAR   = 2'd2
    } seq_op_e;

    // Sub-key code used in a given pass: forward order when encrypting, reversed when decrypting
    function automatic ksel_t pass_key_code(input int pass_idx, input int passes, input logic encrypt);
        int code;
        code = encrypt ? pass_idx : (passes - 1 - pass_idx);
        return ksel_t'(code);
    endfunction

endpackage

// File: rtl/tseq_round_ctr.sv
`timescale 1ns/1ps
// Wrapping round counter over all passes of one block.
// Also gives the count one and two steps ahead, for lookahead decoders.
// Assumes TOTAL >= 3.
module tseq_round_ctr
    import tdes_seq_pkg::*;
#(
    parameter  int TOTAL = 48,
    localparam int CW    = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_op_e       op,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_p1_o,
    output logic [CW-1:0] cnt_p2_o,
    output logic          last_o
);

    localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

    logic [CW-1:0] cnt_q;

    // Modulo-TOTAL increment
    function automatic logic [CW-1:0] wrap_inc(input logic [CW-1:0] v);
        return (v == LAST) ? '0 : v + CW'(1);
    endfunction

    // Count register: clear wins over advance; otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case (op)
                SEQ_CLEAR:   cnt_q <= '0;
                SEQ_ADVANCE: cnt_q <= wrap_inc(cnt_q);
                default:     cnt_q <= cnt_q;
            endcase
        end
    end

    // Lookahead values for the key-select decoder
    always_comb begin
        cnt_p1_o = wrap_inc(cnt_q);
        cnt_p2_o = wrap_inc(cnt_p1_o);
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == LAST);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SEQ_ADVANCE && !last_o) |=> (cnt_q == $past(cnt_q) + CW'(1)));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SEQ_ADVANCE && last_o) |=> (cnt_q == '0));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SEQ_HOLD) |=> $stable(cnt_q));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SEQ_CLEAR) |=> (cnt_q == '0));

endmodule

// File: rtl/tseq_key_sel.sv
`timescale 1ns/1ps
// Registered key-select. Advancing into count n loads the code for the
// pass of count n+1, so the select leads sub-key use by one cycle.
// At count 0 while paused, it refreshes from the direction input.
// Assumes the direction input is steady for the whole block.
module tseq_key_sel
    import tdes_seq_pkg::*;
#(
    parameter  int ROUNDS = 16,
    parameter  int PASSES = 3,
    localparam int TOTAL  = ROUNDS * PASSES,
    localparam int CW     = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_op_e       op,
    input  logic          enc,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cnt_p2,
    output ksel_t         ksel_o
);

    ksel_t ksel_q;
    ksel_t start_code;
    ksel_t ahead_code;

    // Codes for the first pass and for the pass two counts ahead
    always_comb begin
        start_code = pass_key_code(0, PASSES, enc);
        ahead_code = pass_key_code(int'(cnt_p2) / ROUNDS, PASSES, enc);
    end

    // Select register: reset/clear to start code, advance loads lookahead, idle-at-zero refreshes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ksel_q <= start_code;
        end else begin
            case (op)
                SEQ_CLEAR:   ksel_q <= start_code;
                SEQ_ADVANCE: ksel_q <= ahead_code;
                default:     ksel_q <= (cnt == '0) ? start_code : ksel_q;
            endcase
        end
    end

    assign ksel_o = ksel_q;

    p_pause_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SEQ_HOLD && cnt != '0) |=> $stable(ksel_q));

    p_clear_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SEQ_CLEAR) |=> (ksel_q == pass_key_code(0, PASSES, $past(enc))));

    p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ksel_q) < PASSES));

endmodule

// File: rtl/tseq_strobes.sv
`timescale 1ns/1ps
// Decodes the count into round and pass indices, the per-pass key-load
// strobe and the end-of-block valid strobe. Both strobes need an
// advancing cycle. Assumes ROUNDS and PASSES fit the output widths.
module tseq_strobes #(
    parameter  int ROUNDS = 16,
    parameter  int PASSES = 3,
    localparam int TOTAL  = ROUNDS * PASSES,
    localparam int CW     = $clog2(TOTAL),
    localparam int RW     = $clog2(ROUNDS),
    localparam int PW     = (PASSES > 1) ? $clog2(PASSES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [CW-1:0] cnt,
    input  logic          last,
    output logic [RW-1:0] round_o,
    output logic [PW-1:0] pass_o,
    output logic          load_o,
    output logic          valid_o
);

    logic [PASSES-1:0] at_start;

    // One comparator per pass boundary
    for (genvar p = 0; p < PASSES; p++) begin : g_pass_start
        assign at_start[p] = (cnt == CW'(p * ROUNDS));
    end

    // Index decode of the current count
    always_comb begin
        round_o = RW'(int'(cnt) % ROUNDS);
        pass_o  = PW'(int'(cnt) / ROUNDS);
    end

    // Strobes need an advancing cycle
    always_comb begin
        load_o  = active && (|at_start);
        valid_o = active && last;
    end

    p_start_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(at_start));

    p_load_round0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> (round_o == '0));

    p_valid_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

endmodule

// File: rtl/tdes_key_sequencer.sv
`timescale 1ns/1ps
// Iteration sequencer for a three-pass Triple DES engine.
// Turns enable/clear into one operation per cycle, counts rounds,
// and drives the key-select lookahead and the round strobes.
// Assumes enc_i is steady for a block; a change takes effect at count 0.
module tdes_key_sequencer
    import tdes_seq_pkg::*;
#(
    parameter  int ROUNDS = 16,
    parameter  int PASSES = 3,
    localparam int TOTAL  = ROUNDS * PASSES,
    localparam int CW     = $clog2(TOTAL),
    localparam int RW     = $clog2(ROUNDS),
    localparam int PW     = (PASSES > 1) ? $clog2(PASSES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_en_i,
    input  logic              clr_i,
    input  logic              enc_i,
    output logic [RW-1:0]     round_o,
    output logic [PW-1:0]     pass_o,
    output logic              key_load_o,
    output logic [KSEL_W-1:0] key_sel_o,
    output logic              valid_o
);

    seq_op_e       op;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_p1;
    logic [CW-1:0] cnt_p2;
    logic          last;
    ksel_t         ksel;

    // Operation select: clear has priority over advance
    always_comb begin
        if (clr_i)         op = SEQ_CLEAR;
        else if (adv_en_i) op = SEQ_ADVANCE;
        else               op = SEQ_HOLD;
    end

    tseq_round_ctr #(.TOTAL(TOTAL)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .cnt_o    (cnt),
        .cnt_p1_o (cnt_p1),
        .cnt_p2_o (cnt_p2),
        .last_o   (last)
    );

    tseq_key_sel #(.ROUNDS(ROUNDS), .PASSES(PASSES)) u_ksel (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .enc    (enc_i),
        .cnt    (cnt),
        .cnt_p2 (cnt_p2),
        .ksel_o (ksel)
    );

    tseq_strobes #(.ROUNDS(ROUNDS), .PASSES(PASSES)) u_strb (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (op == SEQ_ADVANCE),
        .cnt     (cnt),
        .last    (last),
        .round_o (round_o),
        .pass_o  (pass_o),
        .load_o  (key_load_o),
        .valid_o (valid_o)
    );

    assign key_sel_o = ksel;

    // At each pass load, the select already names that pass's sub-key
    p_load_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (key_load_o && $stable(enc_i)) |-> (key_sel_o == pass_key_code(int'(pass_o), PASSES, enc_i)));

    // The select does not move across the edge into a pass load
    p_slack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SEQ_ADVANCE && round_o == RW'(ROUNDS - 1) && cnt_p1 != '0) |=> $stable(key_sel_o));

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (round_o == '0 && pass_o == '0));

endmodule

// File: tb/tdes_key_sequencer_tb.sv
`timescale 1ns/1ps
module tdes_key_sequencer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adv_en_i = 1'b0;
    logic       clr_i = 1'b0;
    logic       enc_i = 1'b1;
    logic [3:0] round_o;
    logic [1:0] pass_o;
    logic       key_load_o;
    logic [1:0] key_sel_o;
    logic       valid_o;

    int n_cmp = 0;
    int n_bad = 0;
    int m_cnt = 0;
    int m_ks  = 0;

    always #10 clk = ~clk;

    tdes_key_sequencer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_en_i   (adv_en_i),
        .clr_i      (clr_i),
        .enc_i      (enc_i),
        .round_o    (round_o),
        .pass_o     (pass_o),
        .key_load_o (key_load_o),
        .key_sel_o  (key_sel_o),
        .valid_o    (valid_o)
    );

    function automatic int code_of(input int p, input logic enc);
        return enc ? p : 2 - p;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One cycle: drive inputs after the falling edge, check outputs, advance the model by one edge
    task automatic step(input logic en, input logic clr, input logic enc, input string ks_req);
        @(negedge clk);
        adv_en_i = en; clr_i = clr; enc_i = enc;
        #1;
        check("R2", "round", int'(round_o), m_cnt % 16);
        check("R2", "pass", int'(pass_o), m_cnt / 16);
        check(ks_req, "key_sel", int'(key_sel_o), m_ks);
        check("R6", "key_load", int'(key_load_o),
              (en && !clr && (m_cnt % 16 == 0)) ? 1 : 0);
        check("R5", "valid", int'(valid_o), (en && !clr && m_cnt == 47) ? 1 : 0);
        if (clr) begin
            m_cnt = 0;
            m_ks  = code_of(0, enc);
        end else if (en) begin
            m_cnt = (m_cnt + 1) % 48;
            m_ks  = code_of(((m_cnt + 1) % 48) / 16, enc);
        end else if (m_cnt == 0) begin
            m_ks = code_of(0, enc);
        end
    endtask

    task automatic t_reset(input logic enc);
        @(negedge clk);
        rst_n = 1'b0; adv_en_i = 1'b1; clr_i = 1'b0; enc_i = enc;
        @(negedge clk);
        adv_en_i = 1'b0;
        #1;
        check("R1", "round", int'(round_o), 0);
        check("R1", "pass", int'(pass_o), 0);
        check("R1", "key_sel", int'(key_sel_o), enc ? 0 : 2);
        check("R1", "valid", int'(valid_o), 0);
        check("R1", "key_load", int'(key_load_o), 0);
        m_cnt = 0;
        m_ks  = code_of(0, enc);
        rst_n = 1'b1;
    endtask

    // Encrypt block: sequence 00/01/10, select leads each load by one cycle
    task automatic t_encrypt_block();
        step(1'b0, 1'b0, 1'b1, "R10");
        for (int i = 0; i < 48; i++) begin
            step(1'b1, 1'b0, 1'b1, "R3");
            if (i == 15) check("R9", "select ahead of pass 1", int'(key_sel_o), 1);
            if (i == 31) check("R9", "select ahead of pass 2", int'(key_sel_o), 2);
            if (i == 16 || i == 32) check("R9", "load with select held", int'(key_load_o), 1);
        end
        check("R3", "count wrapped", m_cnt, 0);
    endtask

    // Direction change between blocks, then two decrypt blocks back to back
    task automatic t_decrypt_blocks();
        step(1'b0, 1'b0, 1'b0, "R10");
        check("R10", "select after direction change", int'(key_sel_o), 1'b0 ? 0 : 0);
        step(1'b0, 1'b0, 1'b0, "R10");
        check("R10", "refreshed start code", int'(key_sel_o), 2);
        for (int i = 0; i < 96; i++) begin
            step(1'b1, 1'b0, 1'b0, "R4");
        end
    endtask

    // Pause mid-pass and on the final round
    task automatic t_pause();
        step(1'b0, 1'b0, 1'b1, "R10");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1, "R3");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, "R7");
        check("R7", "round held", int'(round_o), 5);
        for (int i = 0; i < 42; i++) step(1'b1, 1'b0, 1'b1, "R3");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, "R7");
        check("R7", "valid low while paused at last round", int'(valid_o), 0);
        step(1'b1, 1'b0, 1'b1, "R3");
        check("R5", "valid on resumed last round", int'(valid_o), 1);
        step(1'b1, 1'b0, 1'b1, "R3");
        check("R5", "valid dropped after one cycle", int'(valid_o), 0);
    endtask

    // Clear during an encrypt block, switch direction, run a full decrypt
    task automatic t_clear();
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b1, "R3");
        step(1'b1, 1'b1, 1'b0, "R8");
        check("R8", "no strobe while clearing", int'(key_load_o) + int'(valid_o), 0);
        step(1'b0, 1'b1, 1'b0, "R8");
        check("R8", "round after clear", int'(round_o), 0);
        check("R8", "start code after clear", int'(key_sel_o), 2);
        for (int i = 0; i < 48; i++) step(1'b1, 1'b0, 1'b0, "R4");
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b1, "R8");
        step(1'b0, 1'b0, 1'b1, "R8");
        check("R8", "encrypt start code after paused clear", int'(key_sel_o), 0);
    endtask

    bit finished = 1'b0;

    initial begin
        t_reset(1'b0);
        t_reset(1'b1);
        t_encrypt_block();
        t_decrypt_blocks();
        t_pause();
        t_clear();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule